// File: doc/BRIEF.md
# Single-Clock FIFO with Selectable Read Timing

This block is a single-clock first-in first-out buffer with a power-of-two depth and a configurable word width. A parameter picks one of two read timings. In standard timing a read request returns its word on the following cycle. In first-word-fall-through timing the oldest word is already on the output whenever one is held, and a read request pops it. A second parameter adds one register stage on the read side to shorten the output timing path.

Both edges of the buffer are protected. A write offered while the buffer is full is dropped, and so is a read offered while it is empty. Stored words and pointers are left untouched, and a one-cycle status pulse reports each dropped access. The producer treats `full` as its back-pressure signal: a word is taken only on a cycle with `wr_en` high and `full` low. The consumer treats `empty` the same way: a read is honoured only on a cycle with `rd_en` high and `empty` low. Write acknowledge, almost-full and almost-empty indications complete the status set.

In first-word-fall-through timing with the output register on, the register holds the word being presented. That word is not in the storage array, so the buffer can hold one word more than the array depth. In this configuration `empty` is the inverse of `rd_valid`.

Top module: `sfifo_dm`

## Requirements
- R1: While reset is held and on the first cycle after it is released, `empty` is 1, and `full`, `rd_valid`, `wr_ack`, `overflow`, `underflow`, `almost_full` and `almost_empty` are 0.
- R2: Words leave the FIFO in the order in which they were accepted.
- R3: A write while `full` is 1 is dropped, no stored word changes, and `overflow` is 1 for one cycle on the next cycle.
- R4: A read while `empty` is 1 is dropped, the read position does not move, `rd_valid` stays 0, and `underflow` is 1 on the next cycle.
- R5: `wr_ack` is 1 on the cycle after each accepted write and 0 after a rejected one.
- R6: In standard timing without the output register, `rdata` carries the word and `rd_valid` is 1 on the cycle after an accepted read. With no read, `rd_valid` is 0.
- R7: In standard timing, enabling the output register delays both `rdata` and `rd_valid` by exactly one more cycle.
- R8: In fall-through timing without the output register, `rd_valid` is 1 and `rdata` shows the oldest word whenever the FIFO holds a word. That is true from the cycle after the write into an empty FIFO. A read moves the output to the next word on the following cycle.
- R9: In fall-through timing with the output register, a word written into an empty FIFO is presented two cycles after the write, and a read pops it.
- R10: `almost_full` is 1 exactly when the storage array has one free slot. `almost_empty` is 1 exactly when the FIFO holds one word.
- R11: A read and a write on the same cycle, with neither blocked, are both accepted and the fill level stays the same.
- R12: `full` is 1 when the storage array holds DEPTH words. In standard timing `empty` is 1 when it holds none. `full` and `empty` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write request |
| wdata | input | WIDTH | Write word |
| full | output | 1 | Storage array full, write back-pressure |
| rd_en | input | 1 | Read request (pop in fall-through timing) |
| rdata | output | WIDTH | Read word |
| empty | output | 1 | No word available to read |
| rd_valid | output | 1 | `rdata` carries a valid word |
| wr_ack | output | 1 | Pulse one cycle after an accepted write |
| overflow | output | 1 | Pulse one cycle after a dropped write |
| underflow | output | 1 | Pulse one cycle after a dropped read |
| almost_full | output | 1 | One free slot left in the storage array |
| almost_empty | output | 1 | Exactly one word held |

## Verification
The bench fills the FIFO to its last slot and then writes once more. A design whose protection is missing would overwrite the oldest word or wrap its fill count, and the drain that follows would return a wrong word or report empty too early. The bench reads from an empty FIFO and checks that no valid word appears. It issues a read and a write together at a fill level of one, then at zero. A design that wrongly accepts the read at zero would return stale data, and one that loses the level on a combined access would report empty one word early. Timing is checked cycle by cycle for all four read configurations, so an output register that adds no latency or two stages of latency would be caught.

// File: rtl/sfifo_dm_pkg.sv
package sfifo_dm_pkg;
  typedef enum logic {
    RD_STD  = 1'b0,
    RD_FWFT = 1'b1
  } rd_mode_e;
endpackage

// File: rtl/sfifo_dm_ptrs.sv
module sfifo_dm_ptrs #(
  parameter int DEPTH = 512,
  localparam int AW = $clog2(DEPTH),
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  output logic [AW-1:0] wr_addr,
  output logic [AW-1:0] rd_addr,
  output logic [LW-1:0] level
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_addr <= '0;
      rd_addr <= '0;
      level   <= '0;
    end else begin
      if (push) wr_addr <= wr_addr + 1'b1;
      if (pop)  rd_addr <= rd_addr + 1'b1;
      if (push && !pop)      level <= level + 1'b1;
      else if (pop && !push) level <= level - 1'b1;
    end
  end

  // R11: a combined push and pop leaves the fill level unchanged
  a_r11_same_level: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop) |=> $stable(level));
endmodule

// File: rtl/sfifo_dm_store.sv
module sfifo_dm_store #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 512,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/sfifo_dm_rdport.sv
module sfifo_dm_rdport
  import sfifo_dm_pkg::*;
#(
  parameter int       WIDTH   = 16,
  parameter rd_mode_e MODE    = RD_STD,
  parameter bit       OUT_REG = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_en,
  input  logic             ram_empty,
  input  logic [WIDTH-1:0] ram_q,
  output logic             ram_rd,
  output logic [WIDTH-1:0] rdata,
  output logic             rd_valid,
  output logic             empty,
  output logic             held
);
  generate
    if (MODE == RD_STD) begin : g_std
      logic [WIDTH-1:0] d1;
      logic             v1;
      assign ram_rd = rd_en && !ram_empty;
      assign empty  = ram_empty;
      assign held   = 1'b0;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          d1 <= '0;
          v1 <= 1'b0;
        end else begin
          v1 <= ram_rd;
          if (ram_rd) d1 <= ram_q;
        end
      end

      if (OUT_REG) begin : g_reg
        logic [WIDTH-1:0] d2;
        logic             v2;
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            d2 <= '0;
            v2 <= 1'b0;
          end else begin
            d2 <= d1;
            v2 <= v1;
          end
        end
        assign rdata    = d2;
        assign rd_valid = v2;
        // R7: the extra stage follows the first one exactly one cycle later
        a_r7_one_stage: assert property (@(posedge clk) disable iff (!rst_n)
          v1 |=> rd_valid);
      end else begin : g_noreg
        assign rdata    = d1;
        assign rd_valid = v1;
      end
    end else begin : g_fwft
      if (OUT_REG) begin : g_reg
        logic [WIDTH-1:0] od;
        logic             ov;
        logic             pop;
        assign pop    = rd_en && ov;
        assign ram_rd = (!ov || pop) && !ram_empty;
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            od <= '0;
            ov <= 1'b0;
          end else begin
            if (ram_rd) begin
              od <= ram_q;
              ov <= 1'b1;
            end else if (pop) begin
              ov <= 1'b0;
            end
          end
        end
        assign rdata    = od;
        assign rd_valid = ov;
        assign empty    = !ov;
        assign held     = ov;
        // R9: the presentation register never idles while the array has words
        a_r9_prefetch: assert property (@(posedge clk) disable iff (!rst_n)
          (!ram_empty && !ov) |=> rd_valid);
      end else begin : g_noreg
        assign ram_rd   = rd_en && !ram_empty;
        assign rdata    = ram_q;
        assign rd_valid = !ram_empty;
        assign empty    = ram_empty;
        assign held     = 1'b0;
      end
    end
  endgenerate
endmodule

// File: rtl/sfifo_dm.sv
module sfifo_dm
  import sfifo_dm_pkg::*;
#(
  parameter int       WIDTH   = 16,
  parameter int       DEPTH   = 512,
  parameter rd_mode_e MODE    = RD_STD,
  parameter bit       OUT_REG = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wdata,
  output logic             full,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rdata,
  output logic             empty,
  output logic             rd_valid,
  output logic             wr_ack,
  output logic             overflow,
  output logic             underflow,
  output logic             almost_full,
  output logic             almost_empty
);
  localparam int AW = $clog2(DEPTH);
  localparam int LW = $clog2(DEPTH + 1);

  logic [AW-1:0]    wr_addr, rd_addr;
  logic [LW-1:0]    level;
  logic [LW-1:0]    occ;
  logic [WIDTH-1:0] ram_q;
  logic             wr_ok, ram_rd, ram_empty, held;

  assign ram_empty = (level == '0);
  assign full      = (level == LW'(DEPTH));
  assign wr_ok     = wr_en && !full;
  assign occ       = level + LW'(held);

  assign almost_full  = (level == LW'(DEPTH - 1));
  assign almost_empty = (occ == LW'(1));

  sfifo_dm_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk     (clk),
    .rst_n   (rst_n),
    .push    (wr_ok),
    .pop     (ram_rd),
    .wr_addr (wr_addr),
    .rd_addr (rd_addr),
    .level   (level)
  );

  sfifo_dm_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_store (
    .clk   (clk),
    .we    (wr_ok),
    .waddr (wr_addr),
    .wdata (wdata),
    .raddr (rd_addr),
    .rdata (ram_q)
  );

  sfifo_dm_rdport #(.WIDTH(WIDTH), .MODE(MODE), .OUT_REG(OUT_REG)) u_rd (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_en     (rd_en),
    .ram_empty (ram_empty),
    .ram_q     (ram_q),
    .ram_rd    (ram_rd),
    .rdata     (rdata),
    .rd_valid  (rd_valid),
    .empty     (empty),
    .held      (held)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ack    <= 1'b0;
      overflow  <= 1'b0;
      underflow <= 1'b0;
    end else begin
      wr_ack    <= wr_ok;
      overflow  <= wr_en && full;
      underflow <= rd_en && empty;
    end
  end

  // R3: a dropped write leaves the write position and the full state alone
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && full && !ram_rd) |=> (full && $stable(wr_addr)));

  // R5: an acknowledge always matches a step of the fill level
  a_r5_ack_level: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ack |-> ($past(ram_rd) || (level == $past(level) + 1'b1)));

  // R12: full and empty exclude each other
  a_r12_flags_apart: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty));

  // R10: almost-full is never shown together with full
  a_r10_almost_full: assert property (@(posedge clk) disable iff (!rst_n)
    almost_full |-> !full);
endmodule

// File: tb/tb_sfifo_dm.sv
`timescale 1ns/1ps
module tb_sfifo_dm;
  import sfifo_dm_pkg::*;

  localparam int W = 16;
  localparam int D = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_en = 1'b0;
  logic         rd_en = 1'b0;
  logic [W-1:0] wdata = '0;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  logic         f0, e0, v0, a0, o0, u0, af0, ae0;
  logic [W-1:0] d0;
  logic         f1, e1, v1, a1, o1, u1, af1, ae1;
  logic [W-1:0] d1;
  logic         f2, e2, v2, a2, o2, u2, af2, ae2;
  logic [W-1:0] d2;
  logic         f3, e3, v3, a3, o3, u3, af3, ae3;
  logic [W-1:0] d3;

  sfifo_dm #(.WIDTH(W), .DEPTH(D), .MODE(RD_STD), .OUT_REG(1'b0)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wdata(wdata), .full(f0),
    .rd_en(rd_en), .rdata(d0), .empty(e0), .rd_valid(v0), .wr_ack(a0),
    .overflow(o0), .underflow(u0), .almost_full(af0), .almost_empty(ae0));

  sfifo_dm #(.WIDTH(W), .DEPTH(D), .MODE(RD_STD), .OUT_REG(1'b1)) dut_sr (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wdata(wdata), .full(f1),
    .rd_en(rd_en), .rdata(d1), .empty(e1), .rd_valid(v1), .wr_ack(a1),
    .overflow(o1), .underflow(u1), .almost_full(af1), .almost_empty(ae1));

  sfifo_dm #(.WIDTH(W), .DEPTH(D), .MODE(RD_FWFT), .OUT_REG(1'b0)) dut_fw (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wdata(wdata), .full(f2),
    .rd_en(rd_en), .rdata(d2), .empty(e2), .rd_valid(v2), .wr_ack(a2),
    .overflow(o2), .underflow(u2), .almost_full(af2), .almost_empty(ae2));

  sfifo_dm #(.WIDTH(W), .DEPTH(D), .MODE(RD_FWFT), .OUT_REG(1'b1)) dut_fr (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wdata(wdata), .full(f3),
    .rd_en(rd_en), .rdata(d3), .empty(e3), .rd_valid(v3), .wr_ack(a3),
    .overflow(o3), .underflow(u3), .almost_full(af3), .almost_empty(ae3));

  // vector: wr, rd, wdata, exp_valid, exp_rdata, exp_empty, exp_ack
  localparam int VN = 8;
  localparam logic [36:0] VEC [VN] = '{
    {1'b1, 1'b0, 16'hA001, 1'b0, 16'h0000, 1'b0, 1'b1},
    {1'b1, 1'b0, 16'hA002, 1'b0, 16'h0000, 1'b0, 1'b1},
    {1'b0, 1'b1, 16'h0000, 1'b1, 16'hA001, 1'b0, 1'b0},
    {1'b1, 1'b1, 16'hA003, 1'b1, 16'hA002, 1'b0, 1'b1},
    {1'b0, 1'b1, 16'h0000, 1'b1, 16'hA003, 1'b1, 1'b0},
    {1'b0, 1'b1, 16'h0000, 1'b0, 16'h0000, 1'b1, 1'b0},
    {1'b1, 1'b1, 16'hA004, 1'b0, 16'h0000, 1'b0, 1'b1},
    {1'b0, 1'b1, 16'h0000, 1'b1, 16'hA004, 1'b1, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    wr_en = 1'b0;
    rd_en = 1'b0;
    wdata = '0;
    step();
    step();
    rst_n = 1'b1;
    step();
  endtask

  initial begin
    #(8.0 * 200000);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state on every configuration
    chk("R1 empty", {e0, e1, e2, e3}, 4'hF);
    chk("R1 full", {f0, f1, f2, f3}, 4'h0);
    chk("R1 valid", {v0, v1, v2, v3}, 4'h0);
    chk("R1 pulses", {a0, o0, u0, af0, ae0, a3, o3, u3}, 8'h00);

    // vector walk on the standard-timing instance (R2, R5, R6, R11)
    for (int i = 0; i < VN; i++) begin
      wr_en = VEC[i][36];
      rd_en = VEC[i][35];
      wdata = VEC[i][34:19];
      step();
      chk("R6 valid", v0, VEC[i][18]);
      if (VEC[i][18]) chk("R2 order", d0, VEC[i][17:2]);
      chk("R11 empty", e0, VEC[i][1]);
      chk("R5 ack", a0, VEC[i][0]);
      if (i == 5) chk("R4 underflow", u0, 1'b1);
    end
    wr_en = 1'b0;
    rd_en = 1'b0;

    // fill to the top, then overflow
    do_reset();
    for (int i = 0; i < D; i++) begin
      wr_en = 1'b1;
      wdata = 16'h0100 + 16'(i);
      step();
      if (i == D - 2) chk("R10 almost_full", {af0, f0}, 2'b10);
    end
    chk("R12 full", {f0, af0}, 2'b10);
    wdata = 16'hDEAD;
    step();
    chk("R3 overflow", o0, 1'b1);
    chk("R5 no ack", a0, 1'b0);
    wr_en = 1'b0;
    step();
    chk("R3 pulse ends", o0, 1'b0);
    for (int i = 0; i < D; i++) begin
      rd_en = 1'b1;
      step();
      chk("R3 contents", {15'd0, v0, d0}, {15'd0, 1'b1, 16'h0100 + 16'(i)});
      if (i == D - 2) chk("R10 almost_empty", ae0, 1'b1);
    end
    rd_en = 1'b0;
    chk("R12 empty", {e0, f0}, 2'b10);
    rd_en = 1'b1;
    step();
    chk("R4 underflow", {u0, v0}, 2'b10);
    rd_en = 1'b0;
    step();
    chk("R4 stays empty", e0, 1'b1);

    // output register latency in standard timing
    do_reset();
    wr_en = 1'b1;
    wdata = 16'h0055;
    step();
    wr_en = 1'b0;
    rd_en = 1'b1;
    step();
    rd_en = 1'b0;
    chk("R6 one cycle", {v0, d0}, {1'b1, 16'h0055});
    chk("R7 not yet", v1, 1'b0);
    step();
    chk("R7 two cycles", {v1, d1}, {1'b1, 16'h0055});
    chk("R6 pulse", v0, 1'b0);

    // fall-through timing, with and without the output register
    do_reset();
    wr_en = 1'b1;
    wdata = 16'h0077;
    step();
    chk("R8 head shown", {v2, d2}, {1'b1, 16'h0077});
    chk("R9 not yet", {v3, e3}, 2'b01);
    wdata = 16'h0078;
    step();
    wr_en = 1'b0;
    chk("R8 head held", {v2, d2}, {1'b1, 16'h0077});
    chk("R9 head shown", {v3, d3}, {1'b1, 16'h0077});
    rd_en = 1'b1;
    step();
    chk("R8 next word", {v2, d2}, {1'b1, 16'h0078});
    chk("R9 next word", {v3, d3}, {1'b1, 16'h0078});
    step();
    rd_en = 1'b0;
    chk("R8 drained", {v2, e2}, 2'b01);
    chk("R9 drained", {v3, e3}, 2'b01);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule